// File: doc/BRIEF.md
# Fixed-Point Load/Store Form Checker and Quadword Beat Sequencer

This block sits between the instruction decoder and the data-cache port of an integer pipeline. For each fixed-point load or store it receives the target register number, the base register number and value, an already-resolved displacement or index value, and flags for update, store, quadword, prefixed encoding, user mode and little-endian mode, plus the access size. It decides whether the request is a legal form, whether it must trap, and otherwise forms the effective address and issues memory beats.

A scalar access issues one beat. A quadword access issues two doubleword beats on consecutive cycles, eight bytes apart, and steers the even/odd register pair according to byte order. Update forms finish with a strobe that writes the effective address back to the base register. When the relaxed quadword rules are not enabled, non-prefixed quadword accesses in user mode or little-endian mode trap. At most one fault is raised per request.

Top module: `ldst_quad_seq`

## Requirements
- R1: A scalar update form whose base register number is 0 raises only the illegal-form flag, issues no beat and no writeback.
- R2: A scalar update load whose base register number equals its target register number raises the illegal-form flag; the same register pairing on an update store is legal and performs the beat and writeback.
- R3: A quadword load whose base register number equals its target register number raises the illegal-form flag; a quadword store with that pairing is legal.
- R4: The effective address is the base value plus the offset, except that base register number 0 contributes zero; the first beat appears in the cycle after acceptance with this address, the store flag, and the requested size (0 byte, 1 halfword, 2 word, 3 doubleword).
- R5: On a legal scalar update form, the cycle after the beat raises the writeback strobe with the base register number and the effective address; a non-update form gives no strobe.
- R6: A legal quadword access gives two consecutive beats of size 3, the first with beat index 0 at the effective address and the second with beat index 1 at the effective address plus 8; the update flag has no effect on a quadword access.
- R7: For a quadword access that is prefixed or big-endian, the first beat selects register rt and the second rt+1 (modulo the register count); for a non-prefixed little-endian one the order is swapped.
- R8: With the relaxed quadword input low, a non-prefixed quadword access in user mode raises the privilege fault.
- R9: With the relaxed quadword input low, a non-prefixed quadword access in little-endian mode (not user mode) raises the alignment fault; prefixed or relaxed accesses raise neither R8 nor R9 faults.
- R10: Faults are exclusive with priority illegal, then privilege, then alignment; the single fault flag is high for one cycle, the cycle after acceptance, and no beat or writeback accompanies it.
- R11: A request is accepted only while req_ready is high; req_ready is low from the cycle after acceptance until the sequence completes, and a request presented meanwhile is ignored.
- R12: After reset all output strobes and fault flags are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_tgt | input | 5 | Target (or source) register number |
| req_base | input | 5 | Base register number |
| req_base_val | input | 64 | Contents of the base register |
| req_offset | input | 64 | Displacement or index value |
| req_size | input | 2 | Scalar access size code |
| req_update | input | 1 | Update form |
| req_store | input | 1 | Store (1) or load (0) |
| req_quad | input | 1 | Quadword access |
| req_prefixed | input | 1 | Prefixed encoding |
| req_user | input | 1 | Issued in user mode |
| req_le | input | 1 | Little-endian mode |
| quad_relaxed | input | 1 | Relaxed quadword rules enabled |
| flt_illegal | output | 1 | Illegal-form fault |
| flt_priv | output | 1 | Privileged-opcode fault |
| flt_align | output | 1 | Alignment fault |
| beat_valid | output | 1 | Memory beat issued |
| beat_idx | output | 1 | 0 for first beat, 1 for second quadword beat |
| beat_addr | output | 64 | Beat address |
| beat_reg | output | 5 | Register selected for the beat |
| beat_size | output | 2 | Beat size code |
| beat_store | output | 1 | Beat is a store |
| wb_valid | output | 1 | Base-register writeback strobe |
| wb_reg | output | 5 | Writeback register number |
| wb_data | output | 64 | Writeback value |

## Verification
Two checks can fire on the same request: an illegal form and a quadword privilege or alignment trap, for instance a user-mode little-endian quadword load whose base equals its target. Such combinations are built deliberately and also arise in random stimulus that biases base and target to collide; the bench expects only the highest-priority flag and no beat. A second overlap is a new request arriving while a sequence is still running; the bench holds a junk request valid across the busy edge and then confirms that the block returns to idle with no extra beat.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FAULT,
        PH_BEAT1,
        PH_BEAT2,
        PH_WB
    } phase_e;

    typedef enum logic [1:0] {
        FLT_NONE,
        FLT_ILLEGAL,
        FLT_PRIV,
        FLT_ALIGN
    } fault_e;

endpackage

// File: rtl/ldst_ea_gen.sv
module ldst_ea_gen #(
    parameter int XLEN = 64,
    parameter int RIDX = 5
) (
    input  logic [RIDX-1:0] base_idx,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] ea
);
    logic [XLEN-1:0] base_term;

    always_comb begin
        base_term = (base_idx == '0) ? '0 : base_val;
        ea        = base_term + offset;
    end
endmodule

// File: rtl/ldst_form_check.sv
module ldst_form_check
    import ldst_pkg::*;
#(
    parameter int RIDX = 5
) (
    input  logic [RIDX-1:0] tgt,
    input  logic [RIDX-1:0] base,
    input  logic            update,
    input  logic            store,
    input  logic            quad,
    input  logic            prefixed,
    input  logic            user,
    input  logic            le,
    input  logic            relaxed,
    output fault_e          fault
);
    logic same_reg;
    logic bad_form;
    logic strict_quad;

    always_comb begin
        same_reg    = (base == tgt);
        if (quad) begin
            bad_form = !store && same_reg;
        end else begin
            bad_form = update && ((base == '0) || (!store && same_reg));
        end
        strict_quad = quad && !relaxed && !prefixed;

        if (bad_form) begin
            fault = FLT_ILLEGAL;
        end else if (strict_quad && user) begin
            fault = FLT_PRIV;
        end else if (strict_quad && le) begin
            fault = FLT_ALIGN;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/ldst_pair_steer.sv
module ldst_pair_steer #(
    parameter int RIDX = 5
) (
    input  logic [RIDX-1:0] tgt,
    input  logic            quad,
    input  logic            prefixed,
    input  logic            le,
    output logic [RIDX-1:0] first_reg,
    output logic [RIDX-1:0] second_reg
);
    logic [RIDX-1:0] odd_reg;
    logic            swap;

    always_comb begin
        odd_reg = tgt + RIDX'(1);
        swap    = quad && le && !prefixed;
        if (swap) begin
            first_reg  = odd_reg;
            second_reg = tgt;
        end else begin
            first_reg  = tgt;
            second_reg = odd_reg;
        end
    end
endmodule

// File: rtl/ldst_quad_seq.sv
module ldst_quad_seq
    import ldst_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NREG   = 32,
    parameter int SIZE_W = 2,
    parameter int DWORD_BYTES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [$clog2(NREG)-1:0]  req_tgt,
    input  logic [$clog2(NREG)-1:0]  req_base,
    input  logic [XLEN-1:0]          req_base_val,
    input  logic [XLEN-1:0]          req_offset,
    input  logic [SIZE_W-1:0]        req_size,
    input  logic                     req_update,
    input  logic                     req_store,
    input  logic                     req_quad,
    input  logic                     req_prefixed,
    input  logic                     req_user,
    input  logic                     req_le,
    input  logic                     quad_relaxed,
    output logic                     flt_illegal,
    output logic                     flt_priv,
    output logic                     flt_align,
    output logic                     beat_valid,
    output logic                     beat_idx,
    output logic [XLEN-1:0]          beat_addr,
    output logic [$clog2(NREG)-1:0]  beat_reg,
    output logic [SIZE_W-1:0]        beat_size,
    output logic                     beat_store,
    output logic                     wb_valid,
    output logic [$clog2(NREG)-1:0]  wb_reg,
    output logic [XLEN-1:0]          wb_data
);
    localparam int RIDX = $clog2(NREG);
    localparam logic [SIZE_W-1:0] SZ_DWORD = SIZE_W'((1 << SIZE_W) - 1);
    localparam logic [XLEN-1:0]   STEP     = XLEN'(DWORD_BYTES);

    typedef struct packed {
        phase_e            phase;
        fault_e            fault;
        logic [XLEN-1:0]   addr;
        logic [RIDX-1:0]   reg_a;
        logic [RIDX-1:0]   reg_b;
        logic [RIDX-1:0]   base;
        logic [SIZE_W-1:0] size;
        logic              store;
        logic              update;
        logic              quad;
    } seq_s;

    seq_s st_d, st_q;

    logic [XLEN-1:0] ea_w;
    fault_e          fault_w;
    logic [RIDX-1:0] first_w;
    logic [RIDX-1:0] second_w;
    logic            accept;

    ldst_ea_gen #(.XLEN(XLEN), .RIDX(RIDX)) u_ea (
        .base_idx (req_base),
        .base_val (req_base_val),
        .offset   (req_offset),
        .ea       (ea_w)
    );

    ldst_form_check #(.RIDX(RIDX)) u_chk (
        .tgt      (req_tgt),
        .base     (req_base),
        .update   (req_update),
        .store    (req_store),
        .quad     (req_quad),
        .prefixed (req_prefixed),
        .user     (req_user),
        .le       (req_le),
        .relaxed  (quad_relaxed),
        .fault    (fault_w)
    );

    ldst_pair_steer #(.RIDX(RIDX)) u_pair (
        .tgt        (req_tgt),
        .quad       (req_quad),
        .prefixed   (req_prefixed),
        .le         (req_le),
        .first_reg  (first_w),
        .second_reg (second_w)
    );

    always_comb begin
        req_ready = (st_q.phase == PH_IDLE);
        accept    = req_valid && req_ready;
        st_d      = st_q;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.fault  = fault_w;
                    st_d.addr   = ea_w;
                    st_d.reg_a  = first_w;
                    st_d.reg_b  = second_w;
                    st_d.base   = req_base;
                    st_d.size   = req_quad ? SZ_DWORD : req_size;
                    st_d.store  = req_store;
                    st_d.update = req_update && !req_quad;
                    st_d.quad   = req_quad;
                    st_d.phase  = (fault_w != FLT_NONE) ? PH_FAULT : PH_BEAT1;
                end
            end
            PH_FAULT: begin
                st_d.phase = PH_IDLE;
                st_d.fault = FLT_NONE;
            end
            PH_BEAT1: begin
                if (st_q.quad) begin
                    st_d.phase = PH_BEAT2;
                    st_d.addr  = st_q.addr + STEP;
                end else if (st_q.update) begin
                    st_d.phase = PH_WB;
                end else begin
                    st_d.phase = PH_IDLE;
                end
            end
            PH_BEAT2: st_d.phase = PH_IDLE;
            PH_WB:    st_d.phase = PH_IDLE;
            default:  st_d.phase = PH_IDLE;
        endcase

        flt_illegal = (st_q.phase == PH_FAULT) && (st_q.fault == FLT_ILLEGAL);
        flt_priv    = (st_q.phase == PH_FAULT) && (st_q.fault == FLT_PRIV);
        flt_align   = (st_q.phase == PH_FAULT) && (st_q.fault == FLT_ALIGN);
        beat_valid  = (st_q.phase == PH_BEAT1) || (st_q.phase == PH_BEAT2);
        beat_idx    = (st_q.phase == PH_BEAT2);
        beat_addr   = st_q.addr;
        beat_reg    = beat_idx ? st_q.reg_b : st_q.reg_a;
        beat_size   = st_q.size;
        beat_store  = st_q.store;
        wb_valid    = (st_q.phase == PH_WB);
        wb_reg      = st_q.base;
        wb_data     = st_q.addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, fault: FLT_NONE, size: '0, default: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ldst_quad_seq_chk.sv
module ldst_quad_seq_chk #(
    parameter int XLEN = 64,
    parameter int RIDX = 5,
    parameter int DWORD_BYTES = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            flt_illegal,
    input logic            flt_priv,
    input logic            flt_align,
    input logic            beat_valid,
    input logic            beat_idx,
    input logic [XLEN-1:0] beat_addr,
    input logic [RIDX-1:0] beat_reg,
    input logic            wb_valid,
    input logic [RIDX-1:0] wb_reg,
    input logic [XLEN-1:0] wb_data
);
    logic any_fault;
    assign any_fault = flt_illegal || flt_priv || flt_align;

    // R10: exclusive faults
    a_r10_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_illegal, flt_priv, flt_align}));

    // R10: no beat or writeback alongside a fault
    a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        any_fault |-> !beat_valid && !wb_valid);

    // R6: second quadword beat follows the first, 8 bytes on
    a_r6_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_idx) |=> (!(beat_valid && beat_idx)) ||
            (beat_addr == $past(beat_addr) + XLEN'(DWORD_BYTES)));

    // R7: the two quadword beats select adjacent registers
    a_r7_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_idx) |=> (!(beat_valid && beat_idx)) ||
            (beat_reg == $past(beat_reg) + RIDX'(1)) ||
            (beat_reg == $past(beat_reg) - RIDX'(1)));

    // R5: writeback carries the address of the preceding beat
    a_r5_wb_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_idx) |=> (!wb_valid) || (wb_data == $past(beat_addr)));

    // R1: never write back to register 0
    a_r1_no_wb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_reg != '0);

    // R11: busy while any output activity is present
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid || wb_valid || any_fault) |-> !req_ready);
endmodule

bind ldst_quad_seq ldst_quad_seq_chk #(
    .XLEN(XLEN), .RIDX(RIDX), .DWORD_BYTES(DWORD_BYTES)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .flt_illegal (flt_illegal),
    .flt_priv    (flt_priv),
    .flt_align   (flt_align),
    .beat_valid  (beat_valid),
    .beat_idx    (beat_idx),
    .beat_addr   (beat_addr),
    .beat_reg    (beat_reg),
    .wb_valid    (wb_valid),
    .wb_reg      (wb_reg),
    .wb_data     (wb_data)
);

// File: tb/ldst_quad_seq_test.sv
module ldst_quad_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_tgt = '0, req_base = '0;
    logic [63:0] req_base_val = '0, req_offset = '0;
    logic [1:0]  req_size = '0;
    logic        req_update = 0, req_store = 0, req_quad = 0;
    logic        req_prefixed = 0, req_user = 0, req_le = 0, quad_relaxed = 0;
    logic        flt_illegal, flt_priv, flt_align;
    logic        beat_valid, beat_idx, beat_store, wb_valid;
    logic [63:0] beat_addr, wb_data;
    logic [4:0]  beat_reg, wb_reg;
    logic [1:0]  beat_size;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ldst_quad_seq uut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected fault: 0 none, 1 illegal, 2 priv, 3 align
    function automatic int exp_fault();
        bit bad, strict;
        if (req_quad) bad = !req_store && (req_base == req_tgt);
        else bad = req_update && (req_base == 0 || (!req_store && req_base == req_tgt));
        strict = req_quad && !quad_relaxed && !req_prefixed;
        if (bad) return 1;
        if (strict && req_user) return 2;
        if (strict && req_le) return 3;
        return 0;
    endfunction

    task automatic run_req();
        int          f;
        logic [63:0] ea;
        logic [4:0]  r0, r1;
        f  = exp_fault();
        ea = ((req_base == 0) ? 64'd0 : req_base_val) + req_offset;
        if (req_quad && req_le && !req_prefixed) begin r0 = req_tgt + 5'd1; r1 = req_tgt; end
        else begin r0 = req_tgt; r1 = req_tgt + 5'd1; end
        check("R11 ready before accept", req_ready, 1);
        req_valid = 1;
        @(posedge clk); @(negedge clk);
        check("R10 illegal flag", flt_illegal, f == 1);
        check("R8 priv flag", flt_priv, f == 2);
        check("R9 align flag", flt_align, f == 3);
        check("R11 busy", req_ready, 0);
        if (f != 0) begin
            check("R10 no beat on fault", beat_valid, 0);
        end else begin
            check("R4 beat valid", beat_valid, 1);
            check("R4 beat addr", beat_addr, ea);
            check("R4 beat size", beat_size, req_quad ? 2'd3 : req_size);
            check("R4 beat store", beat_store, req_store);
            check("R6 first idx", beat_idx, 0);
            check("R7 first reg", beat_reg, r0);
        end
        // junk request held across the busy edge (R11)
        req_tgt = ~req_tgt; req_offset = ~req_offset; req_quad = ~req_quad;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        req_tgt = ~req_tgt; req_offset = ~req_offset; req_quad = ~req_quad;
        if (f == 0 && req_quad) begin
            check("R6 second beat", beat_valid, 1);
            check("R6 second idx", beat_idx, 1);
            check("R6 second addr", beat_addr, ea + 64'd8);
            check("R7 second reg", beat_reg, r1);
            check("R6 no wb on quad", wb_valid, 0);
        end else if (f == 0 && req_update) begin
            check("R5 wb strobe", wb_valid, 1);
            check("R5 wb reg", wb_reg, req_base);
            check("R5 wb data", wb_data, ea);
            check("R5 no beat with wb", beat_valid, 0);
        end else begin
            check("R5 no wb", wb_valid, 0);
            check("R10 single cycle", beat_valid | flt_illegal | flt_priv | flt_align, 0);
        end
        @(posedge clk); @(negedge clk);
        check("R11 idle after sequence", {req_ready, beat_valid, wb_valid,
              flt_illegal, flt_priv, flt_align}, 6'b100000);
    endtask

    task automatic setq(input logic [4:0] t, input logic [4:0] b, input bit upd,
                        input bit st, input bit q, input bit pf, input bit us,
                        input bit le, input bit rl);
        req_tgt = t; req_base = b; req_update = upd; req_store = st; req_quad = q;
        req_prefixed = pf; req_user = us; req_le = le; quad_relaxed = rl;
        req_base_val = 64'h0000_1000_0000_0040; req_offset = 64'h20; req_size = 2'd2;
    endtask

    initial begin
        void'($urandom(32'h1D5E_0007));
        repeat (3) @(negedge clk);
        check("R12 reset ready", req_ready, 1);
        check("R12 reset quiet", {beat_valid, wb_valid, flt_illegal, flt_priv, flt_align}, 0);
        rst_n = 1;
        @(negedge clk);
        check("R12 ready after reset", req_ready, 1);

        setq(5, 0, 1, 0, 0, 0, 0, 0, 0); run_req();        // R1 update base 0
        setq(5, 0, 1, 1, 0, 0, 0, 0, 0); run_req();        // R1 store variant
        setq(7, 7, 1, 0, 0, 0, 0, 0, 0); run_req();        // R2 illegal load
        setq(7, 7, 1, 1, 0, 0, 0, 0, 0); run_req();        // R2 legal store
        setq(8, 8, 0, 0, 1, 1, 0, 0, 0); run_req();        // R3 quad load illegal
        setq(8, 8, 0, 1, 1, 1, 0, 0, 0); run_req();        // R3 quad store legal
        setq(3, 0, 0, 0, 0, 0, 0, 0, 0); run_req();        // R4 base 0 contributes zero
        setq(4, 9, 1, 0, 1, 0, 0, 0, 1); run_req();        // R6 update ignored on quad, R7 BE
        setq(4, 9, 0, 0, 1, 0, 0, 1, 1); run_req();        // R7 LE swapped
        setq(4, 9, 0, 0, 1, 1, 0, 1, 0); run_req();        // R7 prefixed LE not swapped, R9 none
        setq(31, 2, 0, 1, 1, 0, 0, 0, 1); run_req();       // R7 wrap to r0
        setq(4, 9, 0, 0, 1, 0, 1, 0, 0); run_req();        // R8 priv
        setq(4, 9, 0, 0, 1, 0, 0, 1, 0); run_req();        // R9 align
        setq(4, 9, 0, 0, 1, 0, 1, 1, 0); run_req();        // R10 priv beats align
        setq(9, 9, 0, 0, 1, 0, 1, 1, 0); run_req();        // R10 illegal beats priv
        setq(4, 9, 0, 0, 1, 0, 1, 1, 1); run_req();        // R9 relaxed: no fault

        for (int i = 0; i < 400; i++) begin
            req_tgt      = 5'($urandom);
            req_base     = ($urandom % 4 == 0) ? req_tgt : (($urandom % 6 == 0) ? 5'd0 : 5'($urandom));
            req_base_val = {$urandom, $urandom};
            req_offset   = {$urandom, $urandom};
            req_size     = 2'($urandom);
            req_update   = 1'($urandom); req_store = 1'($urandom);
            req_quad     = ($urandom % 3 == 0);
            req_prefixed = 1'($urandom); req_user = 1'($urandom);
            req_le       = 1'($urandom); quad_relaxed = 1'($urandom);
            run_req();
        end
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule